// File: doc/BRIEF.md
# Clock-chip indexed register front end

This block sits between a host and a separate timekeeping core. The host sees two adjacent locations, an index port and a data port. A write to the index port selects one of the clock chip's registers. A read or a write at the data port then reaches the selected register. The index stays in place, so repeated data accesses can reach the same register without setting the index again. Indices below ten (the time, alarm and calendar fields) are passed through to the timekeeping core. The four control and status registers at indices 10 to 13 are held or assembled here.

The block keeps the event flags that the core raises: periodic, alarm and update-ended. It builds a summary bit from the flags whose enables are set and drives an active-low interrupt request from that bit. Reading the flag register returns its contents and then clears every flag. A flag raised in the same cycle as that read is still recorded.

Host requests use a valid/ready handshake. Ready is always high, so a request is accepted in every cycle in which valid is high. Each accepted read produces one response pulse one cycle later. The response has no ready signal and cannot be held back, so the host must take it in the cycle it appears.

Top module: `rtc_regfile_port`

## Requirements
- R1: An accepted write with `req_port`=0 stores the low 7 bits of `req_wdata` as the register index, which appears on `tk_index` after that edge.
- R2: `req_ready` is always 1. Every accepted read gives exactly one `rsp_valid` pulse in the next cycle. Writes give no response. A read with `req_port`=0 returns the index, zero-extended.
- R3: For indices 0 to 9, a data-port write drives `tk_wr_en` with `tk_wdata`=`req_wdata` in the cycle of acceptance, and a data-port read returns `tk_rdata`.
- R4: Register A (index 10) stores bits 6:0, which drive `ctrl_a` and reset to 0x26. Bit 7 reads as `tk_uip`, and a write to bit 7 has no effect.
- R5: Register B (index 11) is 8 bits, read/write, resets to 0x00 and drives `ctrl_b`. Bit 6 enables the periodic flag, bit 5 the alarm flag and bit 4 the update-ended flag.
- R6: Register C (index 12) reads as {IRQF, PF, AF, UF, 4'b0000}. A pulse on `tk_pf_set`, `tk_af_set` or `tk_uf_set` sets its flag whatever the enable. IRQF is 1 when any flag is set together with its enable.
- R7: A data-port read of register C returns the contents before the read and then clears all flags. A set pulse in the same cycle as that read leaves its flag set.
- R8: Data-port writes to register C have no effect on the flags.
- R9: Register D (index 13) reads as {`tk_vrt`, 7'b0000000`}, and writes to it have no effect.
- R10: `irq_n` is 0 exactly when IRQF is 1. It follows changes of flags or enables in the cycle after the edge that stores them.
- R11: Indices 14 to 127 read as 0x00, and writes to them have no effect and do not assert `tk_wr_en`.
- R12: The index holds across any number of data-port accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accept, always 1 |
| req_port | input | 1 | 0 = index port, 1 = data port |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response pulse |
| rsp_data | output | 8 | Read response data |
| tk_index | output | 7 | Current register index |
| tk_wr_en | output | 1 | Write strobe to the timekeeping core |
| tk_wdata | output | 8 | Write data to the core |
| tk_rdata | input | 8 | Core read data for `tk_index` |
| tk_uip | input | 1 | Update-in-progress from the core |
| tk_vrt | input | 1 | RAM and time valid from the core |
| tk_pf_set | input | 1 | Periodic event pulse |
| tk_af_set | input | 1 | Alarm event pulse |
| tk_uf_set | input | 1 | Update-ended event pulse |
| ctrl_a | output | 7 | Register A bits 6:0 |
| ctrl_b | output | 8 | Register B |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A read response is due one cycle after the edge that accepts the request. A stored index, register value or flag change is visible after that same edge. `irq_n` is a combinational decode of the stored flags and enables, so it changes in the same cycle as they do. The bench changes every input on the falling edge and samples every output on the following falling edge. Its monitor pops an expected response only when `rsp_valid` is seen at such a sample point, and it reports any response it did not expect.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;
  localparam int DATA_W    = 8;
  localparam int IDX_W     = 7;
  localparam int NUM_TIME  = 10;
  localparam int IDX_CTL_A = 10;
  localparam int IDX_CTL_B = 11;
  localparam int IDX_FLAGS = 12;
  localparam int IDX_STAT  = 13;
  localparam int NUM_EVT   = 3;
  // event order in the flag vector: [2]=periodic [1]=alarm [0]=update-ended
  localparam int EVT_LSB   = 4;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_TIME, SRC_CTL_A, SRC_CTL_B, SRC_FLAGS, SRC_STAT
  } rd_src_e;
endpackage

// File: rtl/rtc_index_decode.sv
module rtc_index_decode
  import rtc_port_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [IW-1:0] idx_d_i,
  output logic [IW-1:0] idx_q_o,
  output rd_src_e       src_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q_o <= '0;
    else if (load_i) idx_q_o <= idx_d_i;
  end

  always_comb begin
    if (idx_q_o < IW'(NUM_TIME))        src_o = SRC_TIME;
    else if (idx_q_o == IW'(IDX_CTL_A)) src_o = SRC_CTL_A;
    else if (idx_q_o == IW'(IDX_CTL_B)) src_o = SRC_CTL_B;
    else if (idx_q_o == IW'(IDX_FLAGS)) src_o = SRC_FLAGS;
    else if (idx_q_o == IW'(IDX_STAT))  src_o = SRC_STAT;
    else                                src_o = SRC_NONE;
  end
endmodule

// File: rtl/rtc_ctrl_store.sv
module rtc_ctrl_store
  import rtc_port_pkg::*;
#(
  parameter int          DW      = DATA_W,
  parameter logic [DW-2:0] A_RESET = 7'h26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_a_i,
  input  logic          wr_b_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-2:0] ctl_a_o,
  output logic [DW-1:0] ctl_b_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_a_o <= A_RESET;
    else if (wr_a_i) ctl_a_o <= wdata_i[DW-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_b_o <= '0;
    else if (wr_b_i) ctl_b_o <= wdata_i;
  end
endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
  import rtc_port_pkg::*;
#(
  parameter int NE = NUM_EVT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] set_i,
  input  logic [NE-1:0] en_i,
  input  logic          clr_i,
  output logic [NE-1:0] flag_o,
  output logic          sum_o
);
  for (genvar g = 0; g < NE; g++) begin : g_evt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_o[g] <= 1'b0;
      else if (set_i[g]) flag_o[g] <= 1'b1;   // a new event beats the clear
      else if (clr_i)  flag_o[g] <= 1'b0;
    end
  end

  assign sum_o = |(flag_o & en_i);
endmodule

// File: rtl/rtc_regfile_port.sv
module rtc_regfile_port
  import rtc_port_pkg::*;
#(
  parameter int            DW      = DATA_W,
  parameter int            IW      = IDX_W,
  parameter logic [DW-2:0] A_RESET = 7'h26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_port,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [IW-1:0] tk_index,
  output logic          tk_wr_en,
  output logic [DW-1:0] tk_wdata,
  input  logic [DW-1:0] tk_rdata,
  input  logic          tk_uip,
  input  logic          tk_vrt,
  input  logic          tk_pf_set,
  input  logic          tk_af_set,
  input  logic          tk_uf_set,
  output logic [DW-2:0] ctrl_a,
  output logic [DW-1:0] ctrl_b,
  output logic          irq_n
);
  localparam int LOW_W = EVT_LSB;

  rd_src_e             src;
  logic                fire, idx_wr, dat_wr, dat_rd;
  logic [NUM_EVT-1:0]  evt_flags;
  logic                irq_sum;
  logic [DW-1:0]       rd_mux;

  assign req_ready = 1'b1;
  assign fire   = req_valid && req_ready;
  assign idx_wr = fire && !req_port && req_write;
  assign dat_wr = fire && req_port && req_write;
  assign dat_rd = fire && req_port && !req_write;

  rtc_index_decode #(.IW(IW)) u_dec (
    .clk(clk), .rst_n(rst_n), .load_i(idx_wr),
    .idx_d_i(req_wdata[IW-1:0]), .idx_q_o(tk_index), .src_o(src)
  );

  rtc_ctrl_store #(.DW(DW), .A_RESET(A_RESET)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .wr_a_i(dat_wr && src == SRC_CTL_A),
    .wr_b_i(dat_wr && src == SRC_CTL_B),
    .wdata_i(req_wdata), .ctl_a_o(ctrl_a), .ctl_b_o(ctrl_b)
  );

  rtc_flag_unit #(.NE(NUM_EVT)) u_flg (
    .clk(clk), .rst_n(rst_n),
    .set_i({tk_pf_set, tk_af_set, tk_uf_set}),
    .en_i(ctrl_b[EVT_LSB +: NUM_EVT]),
    .clr_i(dat_rd && src == SRC_FLAGS),
    .flag_o(evt_flags), .sum_o(irq_sum)
  );

  assign tk_wr_en = dat_wr && src == SRC_TIME;
  assign tk_wdata = req_wdata;
  assign irq_n    = !irq_sum;

  always_comb begin
    if (!req_port) begin
      rd_mux = {{(DW-IW){1'b0}}, tk_index};
    end else begin
      unique case (src)
        SRC_TIME:  rd_mux = tk_rdata;
        SRC_CTL_A: rd_mux = {tk_uip, ctrl_a};
        SRC_CTL_B: rd_mux = ctrl_b;
        SRC_FLAGS: rd_mux = {irq_sum, evt_flags, {LOW_W{1'b0}}};
        SRC_STAT:  rd_mux = {tk_vrt, {(DW-1){1'b0}}};
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= fire && !req_write;
      if (fire && !req_write) rsp_data <= rd_mux;
    end
  end
endmodule

// File: rtl/rtc_port_checker.sv
module rtc_port_checker #(
  parameter int DW = 8,
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_port,
  input logic          req_write,
  input logic [DW-1:0] req_wdata,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data,
  input logic [IW-1:0] tk_index,
  input logic          tk_wr_en,
  input logic          tk_pf_set,
  input logic          tk_af_set,
  input logic          tk_uf_set,
  input logic [DW-1:0] ctrl_b,
  input logic          irq_n
);
  logic acc_rd, dat_w, rd_flags;
  assign acc_rd   = req_valid && req_ready && !req_write;
  assign dat_w    = req_valid && req_ready && req_port && req_write;
  assign rd_flags = acc_rd && req_port && tk_index == IW'(12);

  a_r1_index_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_port && req_write) |=> tk_index == $past(req_wdata[IW-1:0]));
  a_r2_read_response: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> !rsp_valid);
  a_r3_forward_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_w && tk_index < IW'(10)) |-> tk_wr_en);
  a_r5_b_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_w && tk_index == IW'(11)) |=> ctrl_b == $past(req_wdata));
  a_r6_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flags |=> rsp_data[3:0] == 4'h0);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && !tk_pf_set && !tk_af_set && !tk_uf_set) |=> irq_n);
  a_r7_set_survives: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && tk_pf_set && ctrl_b[6]) |=> !irq_n);
  a_r10_irq_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (tk_af_set && ctrl_b[5] && !(dat_w && tk_index == IW'(11))) |=> !irq_n);
endmodule

bind rtc_regfile_port rtc_port_checker #(.DW(DW), .IW(IW)) u_port_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_port(req_port), .req_write(req_write), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .tk_index(tk_index),
  .tk_wr_en(tk_wr_en), .tk_pf_set(tk_pf_set), .tk_af_set(tk_af_set),
  .tk_uf_set(tk_uf_set), .ctrl_b(ctrl_b), .irq_n(irq_n)
);

// File: tb/test_rtc_regfile_port.sv
`timescale 1ns/1ps
module test_rtc_regfile_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_port = 1'b0, req_write = 1'b0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, rsp_valid, tk_wr_en, irq_n;
  logic [7:0] rsp_data, tk_wdata, ctrl_b;
  logic [7:0] tk_rdata;
  logic [6:0] tk_index, ctrl_a;
  logic       tk_uip = 1'b0, tk_vrt = 1'b0;
  logic       tk_pf_set = 1'b0, tk_af_set = 1'b0, tk_uf_set = 1'b0;

  int n_chk = 0, n_fail = 0, wr_cnt = 0;
  bit done = 0;
  logic [7:0] tm [10];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  rtc_regfile_port i_rtc_regfile_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_port(req_port), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .tk_index(tk_index),
    .tk_wr_en(tk_wr_en), .tk_wdata(tk_wdata), .tk_rdata(tk_rdata),
    .tk_uip(tk_uip), .tk_vrt(tk_vrt), .tk_pf_set(tk_pf_set),
    .tk_af_set(tk_af_set), .tk_uf_set(tk_uf_set), .ctrl_a(ctrl_a),
    .ctrl_b(ctrl_b), .irq_n(irq_n)
  );

  // stand-in for the timekeeping core
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 10; i++) tm[i] <= 8'(8'h90 + i);
    end else if (tk_wr_en) begin
      wr_cnt <= wr_cnt + 1;
      if (tk_index < 7'd10) tm[tk_index] <= tk_wdata;
    end
  end
  assign tk_rdata = (tk_index < 7'd10) ? tm[tk_index] : 8'h5A;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2 unexpected response actual=%h expected=none", rsp_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rsp_data, e, t);
      end
    end
  end

  task automatic acc(input bit p, input bit w, input logic [7:0] d,
                     input logic [7:0] exp, input string tag);
    if (!w) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    req_valid = 1'b1; req_port = p; req_write = w; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic set_idx(input logic [7:0] i);
    acc(1'b0, 1'b1, i, 8'h00, "");
  endtask

  task automatic pulse(input bit pf, input bit af, input bit uf);
    tk_pf_set = pf; tk_af_set = af; tk_uf_set = uf;
    @(posedge clk); @(negedge clk);
    tk_pf_set = 1'b0; tk_af_set = 1'b0; tk_uf_set = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({7'b0, irq_n}, 8'h01, "R10 reset irq_n");
    chk({7'b0, rsp_valid}, 8'h00, "R2 reset rsp_valid");
    chk({1'b0, tk_index}, 8'h00, "R1 reset index");
    chk(ctrl_b, 8'h00, "R5 reset ctrl_b");
    chk({1'b0, ctrl_a}, 8'h26, "R4 reset ctrl_a");
    chk({7'b0, req_ready}, 8'h01, "R2 ready");

    // R1 / R4
    set_idx(8'h8A);
    chk({1'b0, tk_index}, 8'h0A, "R1 index latched low bits");
    acc(1, 0, 0, 8'h26, "R4 read A reset");
    tk_uip = 1'b1;
    acc(1, 0, 0, 8'hA6, "R4 uip bit");
    acc(1, 1, 8'hFF, 0, "");
    chk({7'b0, rsp_valid}, 8'h00, "R2 write no response");
    chk({1'b0, ctrl_a}, 8'h7F, "R4 ctrl_a write");
    acc(1, 0, 0, 8'hFF, "R4 read after write");
    tk_uip = 1'b0;
    acc(1, 0, 0, 8'h7F, "R4 bit7 not stored");
    chk({1'b0, tk_index}, 8'h0A, "R12 index kept");
    acc(0, 0, 0, 8'h0A, "R2 index port read");

    // R5
    set_idx(8'd11);
    acc(1, 1, 8'h70, 0, "");
    chk(ctrl_b, 8'h70, "R5 ctrl_b");
    acc(1, 0, 0, 8'h70, "R5 read B");

    // R3
    set_idx(8'd4);
    acc(1, 1, 8'h12, 0, "");
    chk(8'(wr_cnt), 8'd1, "R3 forwarded write");
    acc(1, 0, 0, 8'h12, "R3 read back time");
    set_idx(8'd9);
    acc(1, 0, 0, 8'h99, "R3 read core value");

    // R11
    set_idx(8'd20);
    acc(1, 1, 8'h33, 0, "");
    chk(8'(wr_cnt), 8'd1, "R11 no forward");
    acc(1, 0, 0, 8'h00, "R11 read zero");

    // R6 R7 R10 with all enables on
    set_idx(8'd12);
    pulse(1, 0, 0);
    chk({7'b0, irq_n}, 8'h00, "R10 irq on periodic");
    acc(1, 0, 0, 8'hC0, "R6 read C");
    chk({7'b0, irq_n}, 8'h01, "R7 cleared irq");
    acc(1, 0, 0, 8'h00, "R7 C empty");

    // enable off: flag still sets
    set_idx(8'd11); acc(1, 1, 8'h00, 0, "");
    pulse(0, 1, 0);
    chk({7'b0, irq_n}, 8'h01, "R10 disabled no irq");
    set_idx(8'd12);
    acc(1, 0, 0, 8'h20, "R6 flag without enable");

    // enable gating of a held flag
    set_idx(8'd11); acc(1, 1, 8'h10, 0, "");
    pulse(0, 0, 1);
    chk({7'b0, irq_n}, 8'h00, "R10 irq on update");
    acc(1, 1, 8'h00, 0, "");
    chk({7'b0, irq_n}, 8'h01, "R10 enable removed");
    acc(1, 1, 8'h10, 0, "");
    chk({7'b0, irq_n}, 8'h00, "R10 enable restored");
    set_idx(8'd12);
    tk_pf_set = 1'b1;
    acc(1, 0, 0, 8'h90, "R7 read with concurrent set");
    tk_pf_set = 1'b0;
    chk({7'b0, irq_n}, 8'h01, "R7 only pf left, not enabled");
    acc(1, 0, 0, 8'h40, "R7 pf survived clear");

    // R8
    acc(1, 1, 8'hF0, 0, "");
    acc(1, 0, 0, 8'h00, "R8 write C ignored");

    // R9
    set_idx(8'd13);
    tk_vrt = 1'b1;
    acc(1, 0, 0, 8'h80, "R9 valid bit");
    acc(1, 1, 8'hFF, 0, "");
    acc(1, 0, 0, 8'h80, "R9 write ignored");
    tk_vrt = 1'b0;
    acc(1, 0, 0, 8'h00, "R9 valid low");
    chk({1'b0, tk_index}, 8'h0D, "R12 index after accesses");

    @(negedge clk);
    chk(8'(exp_q.size()), 8'd0, "R2 all responses seen");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule